// File: doc/BRIEF.md
# I2C Target Address Matcher

This block sits behind the bit-level receiver of an I2C target interface. It looks at the address byte, or bytes, that arrive after a START condition and decides whether the interface should drive an acknowledge. The receiver presents each complete byte with a one-cycle valid strobe. It signals a START or repeated START with its own strobe. Configuration comes in as static inputs:

- a primary own address, either 7-bit or 10-bit;
- a secondary 7-bit own address with a 3-bit mask code;
- three enables, one each for the general call address, the SMBus host address and the SMBus device default address.

For each address byte it examines, the matcher gives a registered decision: a valid pulse and an acknowledge bit. When the address phase ends in a match, it sets a sticky match flag. At the same time it captures the received 7-bit code and the read/write direction. The flag stays set until it is cleared by a strobe. The bit-level pin handling, clock stretching and data bytes belong to other blocks. Once the address phase is over, bytes are ignored until the next START.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, `dec_vld`, `dec_ack`, `hit_flag`, `hit_code` and `hit_read` are all 0.
- R2: When `pri_en`=1 and `pri_ten`=0, a first byte whose bits [7:1] equal `pri_addr[6:0]` is acknowledged. When `pri_en`=0, that primary match gives no acknowledge.
- R3: In 10-bit mode (`pri_en`=1, `pri_ten`=1), a first byte of `{5'b11110, pri_addr[9:8], 0}` is acknowledged without setting the flag. A second byte equal to `pri_addr[7:0]` is then acknowledged and sets the flag, with `hit_code`={5'b11110, pri_addr[9:8]} and `hit_read`=0. A second byte that differs gets no acknowledge.
- R4: A 10-bit header byte with bit 0 = 1 is acknowledged only if the previous address phase ended in a complete 10-bit match. It then sets the flag with `hit_read`=1. Any first byte that is not the own 10-bit header cancels that allowance.
- R5: When `sec_en`=1 and `sec_mask`=k with k from 0 to 6, a first byte is acknowledged when bits [6:k] of its 7-bit address equal bits [6:k] of `sec_addr`. With k=0, all 7 bits must be equal.
- R6: When `sec_en`=1 and `sec_mask`=7, every 7-bit address is acknowledged except the reserved ones, 7'b0000xxx and 7'b1111xxx.
- R7: Address 7'h00 is acknowledged only when `gc_en`=1. Address 7'h08 is acknowledged only when `host_en`=1. Address 7'h61 is acknowledged only when `dflt_en`=1.
- R8: `dec_vld` pulses exactly one cycle after each address byte is strobed. Bytes strobed after the address phase has finished produce no decision until the next `start_det`.
- R9: A match sets `hit_flag` and loads `hit_code` with the received address bits [7:1] and `hit_read` with bit 0. The flag holds until `hit_clr`. If a new match and `hit_clr` fall in the same cycle, the match wins.
- R10: An address byte that is not acknowledged leaves `hit_flag`, `hit_code` and `hit_read` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_det | input | 1 | START or repeated START seen; opens a new address phase |
| byte_vld | input | 1 | One-cycle strobe: `byte_in` holds a complete byte |
| byte_in | input | 8 | Received byte, MSB first on the bus; bit 0 is R/W in a first byte |
| pri_addr | input | 10 | Primary own address |
| pri_ten | input | 1 | Primary address width: 1 = 10-bit, 0 = 7-bit |
| pri_en | input | 1 | Primary address enable |
| sec_addr | input | 7 | Secondary own address |
| sec_mask | input | 3 | Secondary mask code: 0 to 6 ignore that many low bits; 7 accepts all non-reserved addresses |
| sec_en | input | 1 | Secondary address enable |
| gc_en | input | 1 | General call enable |
| host_en | input | 1 | SMBus host address enable |
| dflt_en | input | 1 | SMBus device default address enable |
| hit_clr | input | 1 | Clears the sticky match flag |
| dec_vld | output | 1 | Decision valid pulse |
| dec_ack | output | 1 | Acknowledge decision, valid with `dec_vld` |
| hit_flag | output | 1 | Sticky address-matched flag |
| hit_code | output | 7 | Captured 7-bit address code |
| hit_read | output | 1 | Captured direction: 1 = read (target transmits), 0 = write |

## Verification
The bench builds the matcher with its default special-address parameters: 7'h00, 7'h08 and 7'h61. Those values fall inside and next to the reserved ranges, so a single vector table can show how the enables interact with the masked-all mode of the secondary address. The same table sweeps the mask codes 0, 2, 6 and 7 with addresses that differ just above and just below the masked boundary. Directed sequences then cover the two-byte 10-bit write and the header-only read that depends on it. They also cover bytes that arrive after the address phase and a clear that coincides with a new match.

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter logic [6:0] GCALL_ADDR = 7'h00,
  parameter logic [6:0] HOST_ADDR  = 7'h08,
  parameter logic [6:0] DFLT_ADDR  = 7'h61
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_det,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  input  logic [9:0] pri_addr,
  input  logic       pri_ten,
  input  logic       pri_en,
  input  logic [6:0] sec_addr,
  input  logic [2:0] sec_mask,
  input  logic       sec_en,
  input  logic       gc_en,
  input  logic       host_en,
  input  logic       dflt_en,
  input  logic       hit_clr,
  output logic       dec_vld,
  output logic       dec_ack,
  output logic       hit_flag,
  output logic [6:0] hit_code,
  output logic       hit_read
);

  typedef enum logic [1:0] {PH_IDLE, PH_FIRST, PH_SECOND} phase_t;

  localparam logic [4:0] TEN_HDR = 5'b11110;

  phase_t     phase;
  logic       ten_ok;

  wire  [6:0] rx7   = byte_in[7:1];
  wire        rw    = byte_in[0];
  wire  [6:0] hdr7  = {TEN_HDR, pri_addr[9:8]};
  wire  [6:0] keep  = 7'h7F << sec_mask;

  wire rsvd     = (rx7[6:3] == 4'b0000) || (rx7[6:3] == 4'b1111);
  wire p7_hit   = pri_en && !pri_ten && (rx7 == pri_addr[6:0]);
  wire hdr_hit  = pri_en &&  pri_ten && (rx7 == hdr7);
  wire sec_hit  = sec_en && ((sec_mask == 3'd7) ? !rsvd
                                                : (((rx7 ^ sec_addr) & keep) == 7'd0));
  wire gc_hit   = gc_en   && (rx7 == GCALL_ADDR);
  wire host_hit = host_en && (rx7 == HOST_ADDR);
  wire dflt_hit = dflt_en && (rx7 == DFLT_ADDR);

  wire hdr_wr   = hdr_hit && !rw;
  wire hdr_rd   = hdr_hit &&  rw && ten_ok;
  wire seven    = p7_hit || sec_hit || gc_hit || host_hit || dflt_hit;
  wire first_ack = hdr_wr || hdr_rd || seven;
  wire first_set = first_ack && !hdr_wr;
  wire second_ack = (byte_in == pri_addr[7:0]);

  wire take     = byte_vld && !start_det;
  wire set_hit  = take && (((phase == PH_FIRST) && first_set) ||
                           ((phase == PH_SECOND) && second_ack));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      ten_ok   <= 1'b0;
      dec_vld  <= 1'b0;
      dec_ack  <= 1'b0;
      hit_flag <= 1'b0;
      hit_code <= 7'd0;
      hit_read <= 1'b0;
    end else begin
      dec_vld <= 1'b0;
      dec_ack <= 1'b0;
      if (start_det) begin
        phase <= PH_FIRST;
      end else if (byte_vld) begin
        case (phase)
          PH_FIRST: begin
            dec_vld <= 1'b1;
            dec_ack <= first_ack;
            phase   <= hdr_wr ? PH_SECOND : PH_IDLE;
            if (!hdr_hit) ten_ok <= 1'b0;
          end
          PH_SECOND: begin
            dec_vld <= 1'b1;
            dec_ack <= second_ack;
            ten_ok  <= second_ack;
            phase   <= PH_IDLE;
          end
          default: ;
        endcase
      end

      if (set_hit) begin
        hit_flag <= 1'b1;
        hit_code <= (phase == PH_SECOND) ? hdr7 : rx7;
        hit_read <= (phase == PH_SECOND) ? 1'b0 : rw;
      end else if (hit_clr) begin
        hit_flag <= 1'b0;
      end
    end
  end

  // R8
  ack_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_ack |-> dec_vld);

  // R8
  vld_follows_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |-> $past(byte_vld));

  // R9
  flag_rise_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_flag) |-> (dec_vld && dec_ack));

  // R9
  clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_clr && !byte_vld) |=> !hit_flag);

  // R10
  capture_only_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_ack |-> ($stable(hit_code) && $stable(hit_read)));

endmodule

// File: tb/tb_i2c_addr_match.sv
`timescale 1ns/1ps
module tb_i2c_addr_match;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_det = 1'b0, byte_vld = 1'b0, hit_clr = 1'b0;
  logic [7:0] byte_in = 8'd0;
  logic [9:0] pri_addr = 10'd0;
  logic pri_ten = 1'b0, pri_en = 1'b0;
  logic [6:0] sec_addr = 7'd0;
  logic [2:0] sec_mask = 3'd0;
  logic sec_en = 1'b0, gc_en = 1'b0, host_en = 1'b0, dflt_en = 1'b0;
  logic dec_vld, dec_ack, hit_flag, hit_read;
  logic [6:0] hit_code;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  i2c_addr_match dut (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .byte_vld(byte_vld),
    .byte_in(byte_in), .pri_addr(pri_addr), .pri_ten(pri_ten), .pri_en(pri_en),
    .sec_addr(sec_addr), .sec_mask(sec_mask), .sec_en(sec_en), .gc_en(gc_en),
    .host_en(host_en), .dflt_en(dflt_en), .hit_clr(hit_clr), .dec_vld(dec_vld),
    .dec_ack(dec_ack), .hit_flag(hit_flag), .hit_code(hit_code), .hit_read(hit_read)
  );

  // {pri_en, pri_ten, pri_addr[9:0], sec_en, sec_addr[6:0], sec_mask[2:0],
  //  gc_en, host_en, dflt_en, byte[7:0], expected ack}
  localparam int NV = 17;
  localparam logic [34:0] VEC [NV] = '{
    {1'b1, 1'b0, 10'h03A, 1'b0, 7'h00, 3'd0, 1'b0, 1'b0, 1'b0, 8'h74, 1'b1}, // R2
    {1'b0, 1'b0, 10'h03A, 1'b0, 7'h00, 3'd0, 1'b0, 1'b0, 1'b0, 8'h74, 1'b0}, // R2
    {1'b0, 1'b0, 10'h000, 1'b1, 7'h55, 3'd0, 1'b0, 1'b0, 1'b0, 8'hAA, 1'b1}, // R5
    {1'b0, 1'b0, 10'h000, 1'b1, 7'h55, 3'd0, 1'b0, 1'b0, 1'b0, 8'hA8, 1'b0}, // R5
    {1'b0, 1'b0, 10'h000, 1'b1, 7'h55, 3'd2, 1'b0, 1'b0, 1'b0, 8'hAD, 1'b1}, // R5
    {1'b0, 1'b0, 10'h000, 1'b1, 7'h55, 3'd2, 1'b0, 1'b0, 1'b0, 8'hB2, 1'b0}, // R5
    {1'b0, 1'b0, 10'h000, 1'b1, 7'h55, 3'd6, 1'b0, 1'b0, 1'b0, 8'h80, 1'b1}, // R5
    {1'b0, 1'b0, 10'h000, 1'b1, 7'h55, 3'd7, 1'b0, 1'b0, 1'b0, 8'h44, 1'b1}, // R6
    {1'b0, 1'b0, 10'h000, 1'b1, 7'h55, 3'd7, 1'b0, 1'b0, 1'b0, 8'h06, 1'b0}, // R6
    {1'b0, 1'b0, 10'h000, 1'b1, 7'h55, 3'd7, 1'b0, 1'b0, 1'b0, 8'hF8, 1'b0}, // R6
    {1'b0, 1'b0, 10'h000, 1'b0, 7'h55, 3'd7, 1'b0, 1'b0, 1'b0, 8'h44, 1'b0}, // R6
    {1'b0, 1'b0, 10'h000, 1'b0, 7'h00, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1}, // R7
    {1'b0, 1'b0, 10'h000, 1'b0, 7'h00, 3'd0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0}, // R7
    {1'b0, 1'b0, 10'h000, 1'b0, 7'h00, 3'd0, 1'b0, 1'b1, 1'b0, 8'h10, 1'b1}, // R7
    {1'b0, 1'b0, 10'h000, 1'b0, 7'h00, 3'd0, 1'b0, 1'b0, 1'b1, 8'hC2, 1'b1}, // R7
    {1'b0, 1'b0, 10'h000, 1'b0, 7'h00, 3'd0, 1'b0, 1'b1, 1'b0, 8'hC2, 1'b0}, // R7
    {1'b0, 1'b0, 10'h000, 1'b1, 7'h55, 3'd7, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0}  // R6
  };

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_start();
    start_det = 1'b1; tick(); start_det = 1'b0;
  endtask

  task automatic do_clear();
    hit_clr = 1'b1; tick(); hit_clr = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    byte_in = b; byte_vld = 1'b1; tick(); byte_vld = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R1 reset state
    check("R1 dec_vld", dec_vld, 0);
    check("R1 hit_flag", hit_flag, 0);
    check("R1 hit_code", hit_code, 0);
    check("R1 hit_read", hit_read, 0);
    rst_n = 1'b1;
    tick();
    check("R1 dec_ack", dec_ack, 0);

    for (int i = 0; i < NV; i++) begin
      logic [34:0] v;
      v = VEC[i];
      pri_en = v[34]; pri_ten = v[33]; pri_addr = v[32:23];
      sec_en = v[22]; sec_addr = v[21:15]; sec_mask = v[14:12];
      gc_en = v[11]; host_en = v[10]; dflt_en = v[9];
      do_clear();
      do_start();
      send(v[8:1]);
      check($sformatf("R2/R5/R6/R7 vec%0d vld", i), dec_vld, 1);
      check($sformatf("R2/R5/R6/R7 vec%0d ack", i), dec_ack, v[0]);
      check($sformatf("R9 vec%0d flag", i), hit_flag, v[0]);
      if (v[0]) begin
        check($sformatf("R9 vec%0d code", i), hit_code, v[8:2]);
        check($sformatf("R9 vec%0d dir", i), hit_read, v[1]);
      end
    end

    // R10: nack keeps captured state (flag set from last ack above)
    pri_en = 1'b1; pri_ten = 1'b0; pri_addr = 10'h03A;
    sec_en = 1'b0; gc_en = 1'b0; host_en = 1'b0; dflt_en = 1'b0;
    do_clear(); do_start(); send(8'h75);
    check("R9 read dir", hit_read, 1);
    check("R9 code", hit_code, 7'h3A);
    do_start(); send(8'h20);
    check("R10 nack", dec_ack, 0);
    check("R10 flag kept", hit_flag, 1);
    check("R10 code kept", hit_code, 7'h3A);
    check("R10 dir kept", hit_read, 1);

    // R8: byte after address phase yields no decision
    send(8'h74);
    check("R8 no decision after phase", dec_vld, 0);
    tick();
    check("R8 quiet", dec_vld, 0);

    // R9: clear alone, then clear colliding with a match
    do_clear();
    check("R9 clear", hit_flag, 0);
    do_start();
    hit_clr = 1'b1; send(8'h74); hit_clr = 1'b0;
    check("R9 set wins over clear", hit_flag, 1);

    // R3: 10-bit write, pri_addr=10'h2C5 -> header byte F4, second C5
    pri_ten = 1'b1; pri_addr = 10'h2C5;
    do_clear(); do_start(); send(8'hF4);
    check("R3 header ack", dec_ack, 1);
    check("R3 header no flag", hit_flag, 0);
    send(8'hC5);
    check("R3 second vld", dec_vld, 1);
    check("R3 second ack", dec_ack, 1);
    check("R3 flag", hit_flag, 1);
    check("R3 code", hit_code, 7'h7A);
    check("R3 dir", hit_read, 0);

    // R4: header read after full 10-bit match
    do_clear(); do_start(); send(8'hF5);
    check("R4 read header ack", dec_ack, 1);
    check("R4 flag", hit_flag, 1);
    check("R4 dir", hit_read, 1);
    check("R4 code", hit_code, 7'h7A);
    do_start(); send(8'h20);
    check("R4 other addr nack", dec_ack, 0);
    do_clear(); do_start(); send(8'hF5);
    check("R4 read header refused", dec_ack, 0);
    check("R4 no flag", hit_flag, 0);

    // R3: second byte mismatch and wrong high bits
    do_start(); send(8'hF4); send(8'hC4);
    check("R3 second mismatch vld", dec_vld, 1);
    check("R3 second mismatch nack", dec_ack, 0);
    check("R3 mismatch no flag", hit_flag, 0);
    do_start(); send(8'hF2);
    check("R3 wrong high bits nack", dec_ack, 0);
    do_start(); send(8'hF4);
    pri_en = 1'b0;
    send(8'hC5);
    check("R3 second byte needs only value", dec_ack, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule